// File: doc/BRIEF.md
# Imager Front-End Power-Up Sequencer

This controller sits on the host side of an imaging analog front end. It runs the register bring-up once the supplies, the master clock and the sync signals are already present. A single start pulse launches a fixed, ordered series of register writes. The writes leave on a plain request interface that carries an address, a data byte and a valid/ready handshake. A serial link or other transport behind that interface carries them to the front end.

The sequence first applies a soft reset. It then pulses the active-low reset of the timing core and sets the hold that stops register updates from taking effect. With the hold set, the sequencer streams a user table of timing configuration writes. It then programs the test-mode field and turns on the output enable. The last write releases the hold, so every new setting takes effect together at the front end's next sync edge.

The user table is outside the block. The sequencer presents an index and reads back an address/data pair through combinational lookup. A busy flag and a step code make progress visible. A done flag reports completion.

Top module: `fe_bringup_seq`

## Requirements
- R1: After reset the block is idle: `wr_valid`, `busy` and `done` are low and `step` is 0.
- R2: While idle, a `start` pulse sets `busy` in the next cycle. The first write request is then address 0x10 with data 0x01 (soft reset).
- R3: The next two writes go to the active-low timing-core reset at address 0x12: first data 0x00, then data 0x01.
- R4: The next write is address 0x14 with data 0x01 (update hold set). It comes before any user write.
- R5: Next come the user writes, in table order from index 0. While user write k is pending, `cfg_idx` equals k, and the request carries `cfg_addr`/`cfg_data` unchanged. A count of 0 skips the user step.
- R6: The user count is sampled from `cfg_count` when the start is accepted. A value above 64 is treated as 64.
- R7: After the user writes, the sequencer writes data 0xC0 to address 0x00. This sets test-mode bits [7:6] to 3 and leaves bits [5:0] at 0.
- R8: Next it writes address 0x11 with data 0x01 (output enable). The final write is address 0x14 with data 0x00 (hold release).
- R9: A request stays asserted with a stable address and data until `wr_ready` is high. The sequence advances by exactly one write per cycle in which both `wr_valid` and `wr_ready` are high.
- R10: In the cycle after the final write's handshake, `busy` falls and `done` rises. `done` then stays high until the next accepted start clears it.
- R11: A `start` pulse while `busy` is high is ignored. The sequence, the count and the outputs continue unchanged.
- R12: `step` reports the pending write's phase with this encoding: 0 idle, 1 soft reset, 2 core reset low, 3 core reset high, 4 hold set, 5 user writes, 6 test mode, 7 output enable, 8 hold release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| cfg_count | input | 7 | Number of user table entries, clamped to 64 |
| cfg_idx | output | 6 | Index of the user entry being requested |
| cfg_addr | input | 8 | Address of table entry `cfg_idx` |
| cfg_data | input | 8 | Data of table entry `cfg_idx` |
| wr_valid | output | 1 | Write request pending |
| wr_addr | output | 8 | Register address of the request |
| wr_data | output | 8 | Register data of the request |
| wr_ready | input | 1 | Downstream accepts the request this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed since last start |
| step | output | 4 | Phase code of the pending write |

## Verification
The hardest points to reach from the ports are the phase boundaries when `wr_ready` is low. Examples are a stalled last user write, whose request must not slip into the test-mode write, and a stalled hold release, which must keep `done` low. A second hard case is a start pulse that arrives in the middle of a run. The stimulus drives `wr_ready` from a pseudo-random sequence and adds stray start pulses while busy. It runs counts of 0, 3, 64 and 70, so each stall lands on different phase boundaries. A behavioural queue of expected writes is compared against the outputs on every cycle.

// File: rtl/fe_bringup_pkg.sv
package fe_bringup_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SOFT_RST  = 8'h10;
    localparam logic [ADDR_W-1:0] A_CORE_RSTN = 8'h12;
    localparam logic [ADDR_W-1:0] A_HOLD      = 8'h14;
    localparam logic [ADDR_W-1:0] A_TEST_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] A_OUT_EN    = 8'h11;

    localparam logic [1:0] TEST_MODE_VAL = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_SOFT_RST = 4'd1,
        ST_CORE_LO  = 4'd2,
        ST_CORE_HI  = 4'd3,
        ST_HOLD_SET = 4'd4,
        ST_USER     = 4'd5,
        ST_TEST     = 4'd6,
        ST_OUT_EN   = 4'd7,
        ST_HOLD_CLR = 4'd8
    } step_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic wr_req_t fixed_write(input step_e s);
        wr_req_t r;
        r = '0;
        case (s)
            ST_SOFT_RST: begin r.addr = A_SOFT_RST;  r.data = 8'h01; end
            ST_CORE_LO:  begin r.addr = A_CORE_RSTN; r.data = 8'h00; end
            ST_CORE_HI:  begin r.addr = A_CORE_RSTN; r.data = 8'h01; end
            ST_HOLD_SET: begin r.addr = A_HOLD;      r.data = 8'h01; end
            ST_TEST:     begin r.addr = A_TEST_MODE; r.data = {TEST_MODE_VAL, 6'b0}; end
            ST_OUT_EN:   begin r.addr = A_OUT_EN;    r.data = 8'h01; end
            ST_HOLD_CLR: begin r.addr = A_HOLD;      r.data = 8'h00; end
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fe_step_ctrl.sv
module fe_step_ctrl
    import fe_bringup_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  hs,
    input  logic  cfg_last,
    input  logic  cfg_empty,
    output step_e state,
    output logic  done,
    output logic  load,
    output logic  cfg_adv
);
    step_e state_q, state_d;
    logic  done_q;

    assign load    = (state_q == ST_IDLE) && start;
    assign cfg_adv = (state_q == ST_USER) && hs;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_SOFT_RST;
        end else if (hs) begin
            case (state_q)
                ST_SOFT_RST: state_d = ST_CORE_LO;
                ST_CORE_LO:  state_d = ST_CORE_HI;
                ST_CORE_HI:  state_d = ST_HOLD_SET;
                ST_HOLD_SET: state_d = cfg_empty ? ST_TEST : ST_USER;
                ST_USER:     state_d = cfg_last ? ST_TEST : ST_USER;
                ST_TEST:     state_d = ST_OUT_EN;
                ST_OUT_EN:   state_d = ST_HOLD_CLR;
                ST_HOLD_CLR: state_d = ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load)
                done_q <= 1'b0;
            else if (hs && state_q == ST_HOLD_CLR)
                done_q <= 1'b1;
        end
    end

    assign state = state_q;
    assign done  = done_q;
endmodule

// File: rtl/fe_cfg_index.sv
module fe_cfg_index #(
    parameter int MAX_CFG = 64,
    localparam int IDX_W  = $clog2(MAX_CFG),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] count_in,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             empty
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CFG);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            cnt_q <= (count_in > CNT_MAX) ? CNT_MAX : count_in;
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx   = idx_q;
    assign empty = (cnt_q == '0);
    assign last  = ({1'b0, idx_q} == (cnt_q - CNT_W'(1)));
endmodule

// File: rtl/fe_write_mux.sv
module fe_write_mux
    import fe_bringup_pkg::*;
(
    input  step_e             state,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    output wr_req_t           req,
    output logic              valid
);
    always_comb begin
        if (state == ST_USER) begin
            req.addr = cfg_addr;
            req.data = cfg_data;
        end else begin
            req = fixed_write(state);
        end
        valid = (state != ST_IDLE);
    end
endmodule

// File: rtl/fe_bringup_seq.sv
module fe_bringup_seq
    import fe_bringup_pkg::*;
#(
    parameter int MAX_CFG = 64,
    localparam int IDX_W  = $clog2(MAX_CFG),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_count,
    output logic [IDX_W-1:0] cfg_idx,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_data,
    output logic             wr_valid,
    output logic [7:0]       wr_addr,
    output logic [7:0]       wr_data,
    input  logic             wr_ready,
    output logic             busy,
    output logic             done,
    output logic [3:0]       step
);
    step_e   state;
    wr_req_t req;
    logic    hs, load, cfg_adv, cfg_last, cfg_empty, valid;

    assign hs = valid && wr_ready;

    fe_step_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .hs        (hs),
        .cfg_last  (cfg_last),
        .cfg_empty (cfg_empty),
        .state     (state),
        .done      (done),
        .load      (load),
        .cfg_adv   (cfg_adv)
    );

    fe_cfg_index #(.MAX_CFG(MAX_CFG)) u_idx (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .count_in (cfg_count),
        .adv      (cfg_adv),
        .idx      (cfg_idx),
        .last     (cfg_last),
        .empty    (cfg_empty)
    );

    fe_write_mux u_mux (
        .state    (state),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .req      (req),
        .valid    (valid)
    );

    assign wr_valid = valid;
    assign wr_addr  = req.addr;
    assign wr_data  = req.data;
    assign busy     = (state != ST_IDLE);
    assign step     = 4'(state);
endmodule

// File: rtl/fe_bringup_chk.sv
module fe_bringup_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       wr_valid,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       wr_ready,
    input logic       busy,
    input logic       done,
    input logic [3:0] step
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_valid && step == 4'd0); // R1

    AST_FIRST_SOFT_RST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wr_addr == 8'h10 && wr_data == 8'h01 && $past(start)); // R2

    AST_CORE_PAIR: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready && step == 4'd2 |=> wr_addr == 8'h12 && wr_data == 8'h01); // R3

    AST_TEST_FIELD: assert property (@(posedge clk) disable iff (rst)
        step == 4'd6 |-> wr_addr == 8'h00 && wr_data == 8'hC0); // R7

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(step)); // R9

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done && $past(wr_addr) == 8'h14 && $past(wr_data) == 8'h00); // R8

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start && !(wr_valid && wr_ready) |=> $stable(step)); // R11
endmodule

bind fe_bringup_seq fe_bringup_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .busy     (busy),
    .done     (done),
    .step     (step)
);

// File: tb/test_fe_bringup_seq.sv
module test_fe_bringup_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] cfg_count = '0;
    logic [5:0] cfg_idx;
    logic [7:0] cfg_addr, cfg_data;
    logic       wr_valid, wr_ready = 1'b0;
    logic [7:0] wr_addr, wr_data;
    logic       busy, done;
    logic [3:0] step;

    always #4 clk = ~clk;   // 125 MHz

    // user table: entry i -> address 0x20+i, data 3*i+5
    assign cfg_addr = 8'h20 + 8'(cfg_idx);
    assign cfg_data = 8'(3 * int'(cfg_idx) + 5);

    fe_bringup_seq i_fe_bringup_seq (
        .clk(clk), .rst(rst), .start(start), .cfg_count(cfg_count),
        .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .busy(busy), .done(done), .step(step)
    );

    typedef struct {
        int addr;
        int data;
        int stp;
        int idx;
    } item_t;

    item_t q[$];
    bit    m_active = 0;
    bit    m_done   = 0;
    int    n_chk    = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input int a, input int d, input int s, input int i);
        item_t it;
        it.addr = a; it.data = d; it.stp = s; it.idx = i;
        q.push_back(it);
    endtask

    task automatic check_outputs();
        chk(busy === m_active, "R10 busy", int'(busy), int'(m_active));
        chk(done === m_done,   "R10 done", int'(done), int'(m_done));
        chk(wr_valid === m_active, "R9 valid", int'(wr_valid), int'(m_active));
        if (m_active) begin
            chk(int'(wr_addr) == q[0].addr, "R2-R8 addr", int'(wr_addr), q[0].addr);
            chk(int'(wr_data) == q[0].data, "R2-R8 data", int'(wr_data), q[0].data);
            chk(int'(step) == q[0].stp, "R12 step", int'(step), q[0].stp);
            if (q[0].stp == 5)
                chk(int'(cfg_idx) == q[0].idx, "R5 cfg_idx", int'(cfg_idx), q[0].idx);
        end else begin
            chk(step == 4'd0, "R1 R12 idle step", int'(step), 0);
        end
    endtask

    // one cycle: check at negedge, drive inputs, predict the next posedge
    task automatic tick(input bit st, input bit rdy, input int cnt);
        int n;
        @(negedge clk);
        check_outputs();
        start     = st;
        wr_ready  = rdy;
        cfg_count = 7'(cnt);
        if (!m_active && st) begin
            n = (cnt > 64) ? 64 : cnt;           // R6
            push(8'h10, 8'h01, 1, 0);            // R2
            push(8'h12, 8'h00, 2, 0);            // R3
            push(8'h12, 8'h01, 3, 0);
            push(8'h14, 8'h01, 4, 0);            // R4
            for (int i = 0; i < n; i++)          // R5
                push(8'h20 + i, (3 * i + 5) & 8'hFF, 5, i);
            push(8'h00, 8'hC0, 6, 0);            // R7
            push(8'h11, 8'h01, 7, 0);            // R8
            push(8'h14, 8'h00, 8, 0);
            m_active = 1;
            m_done   = 0;
        end else if (m_active && rdy) begin
            void'(q.pop_front());
            if (q.size() == 0) begin
                m_active = 0;
                m_done   = 1;
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // mode 0: always ready; 1: random ready; 2: random ready plus stray starts (R11)
    task automatic run(input int cnt, input int mode);
        tick(1'b1, lfsr[1], cnt);
        while (m_active) begin
            if (mode == 0)
                tick(1'b0, 1'b1, cnt);
            else
                tick(mode == 2 && lfsr[5] && lfsr[7], lfsr[0] | lfsr[3], (mode == 2) ? 3 : cnt);
        end
        repeat (5) tick(1'b0, lfsr[2], 0);   // R10 done held while idle
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) tick(1'b0, 1'b0, 0);       // R1 reset state
        run(3, 0);                            // R2..R8 basic order
        run(0, 1);                            // R5 empty table, R9 stalls
        run(70, 2);                           // R6 clamp, R11 stray starts
        run(64, 1);                           // R5 full table
        run(5, 2);                            // R11 count change ignored mid-run
        tick(1'b0, 1'b0, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule